// File: doc/BRIEF.md
# Signed Restoring Divider

This block divides one N-bit two's-complement integer by another over several clock cycles. A pulse on `start_i` while the block is idle captures both operands. The dividend is sign-extended into a double-width working pair: a partial remainder in the upper half and the dividend bits in the lower half. The block then runs one shift-and-trial step per cycle for N cycles. Each step shifts the pair left and adds or subtracts the divisor, depending on the signs of the partial remainder and the divisor. The step keeps the new partial remainder when its sign is unchanged, or when it is zero and no unconsumed dividend bits are left. Otherwise it restores the old value. Each step writes one quotient bit.

One more cycle negates the quotient when the operand signs differ. `done_o` then pulses for one cycle. The quotient and remainder stay on the outputs until the next accepted start. A zero divisor skips the iterations: the block reports the condition on `div_by_zero_o` and finishes at once.

Top module: `sdiv_restoring`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `div_by_zero_o` are 0, and `quotient_o` and `remainder_o` are all zeros.
- R2: When `start_i` is sampled high while idle with a nonzero divisor, `busy_o` is high from the next cycle. `done_o` is high for exactly one cycle, N+1 clock edges after the capturing edge, and `busy_o` falls together with the rise of `done_o`.
- R3: For a nonzero divisor, `quotient_o` equals the dividend divided by the divisor, rounded toward zero, as an N-bit two's-complement value.
- R4: For a nonzero divisor, `remainder_o` equals dividend − quotient × divisor. It is either zero or has the sign of the dividend, and its magnitude is below that of the divisor.
- R5: An exact division with a negative dividend gives remainder 0 and the exact quotient (for N=4: −6/2 gives 1101 r 0000, and −4/2 gives 1110 r 0000). This needs the zero test that looks only at dividend bits not yet shifted out.
- R6: For N=4, −7/2 gives quotient 1101 and remainder 1111, and 6/−3 gives quotient 1110 and remainder 0000.
- R7: The most negative dividend divided by −1 gives the most negative value as quotient (the result wraps to N bits) and remainder 0.
- R8: A zero divisor makes `done_o` and `div_by_zero_o` high on the cycle after the capturing edge, and `busy_o` never rises. `div_by_zero_o` then stays high until the next accepted start. The quotient and remainder are unspecified in that case.
- R9: `start_i` is ignored while `busy_o` is high: the operation in flight completes with its own operands and its own latency.
- R10: `div_by_zero_o` is 0 on every completion with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| dividend_i | input | N | Two's-complement dividend |
| divisor_i | input | N | Two's-complement divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | N | Quotient, valid from `done_o` until the next start |
| remainder_o | output | N | Remainder, valid from `done_o` until the next start |
| div_by_zero_o | output | 1 | The last accepted divisor was zero |

## Verification
The bench sweeps every pair of 4-bit operands and compares the results with truncating integer division worked out in the bench.

That sweep covers the exact negative divisions. There, a design that ignored the remaining-dividend test, or tested all of Q, would restore the wrong step and return a quotient one off with a remainder equal to ±divisor. It also covers the most-negative dividend over −1, which a faulty sign correction turns into a wrong wrap. Divisors of −8 would expose a shift that overflowed the partial remainder.

Separate runs check the zero-divisor shortcut, the flag clearing on the next good division, and a start pulse during a busy run. A design that accepted that pulse would return the second operands' result or a shortened latency.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_step.sv
// One restoring iteration: shift {A,Q}, trial add/sub, keep or restore.
module sdiv_step #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] q_i,
  input  logic [N-1:0] m_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] a_o,
  output logic [N-1:0] q_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] a_sh, q_sh, trial;
  logic         same_sign, rest_zero, keep;

  always_comb begin
    a_sh      = {a_i[N-2:0], q_i[N-1]};
    q_sh      = {q_i[N-2:0], 1'b0};
    mask_o    = {mask_i[N-2:0], 1'b0};
    trial     = (a_sh[N-1] == m_i[N-1]) ? (a_sh - m_i) : (a_sh + m_i);
    same_sign = (trial[N-1] == a_sh[N-1]);
    // zero test only over dividend bits not yet shifted into A
    rest_zero = (trial == '0) && ((q_sh & mask_o) == '0);
    keep      = same_sign || rest_zero;
    a_o       = keep ? trial : a_sh;
    q_o       = {q_sh[N-1:1], keep};
  end
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_div_i,
  output logic load_o,
  output logic iter_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(N + 1);

  sdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign iter_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fix_o || (load_o && zero_div_i);
      unique case (state_q)
        ST_IDLE: if (load_o && !zero_div_i) begin
          state_q <= ST_RUN;
          cnt_q   <= CW'(N);
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_run_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == CW'(1)) |=> (state_q == ST_FIX));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/sdiv_restoring.sv
module sdiv_restoring #(
  parameter int unsigned N = 4  // N >= 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] quotient_o,
  output logic [N-1:0] remainder_o,
  output logic         div_by_zero_o
);
  logic [N-1:0] a_q, q_q, m_q, mask_q;
  logic [N-1:0] a_nxt, q_nxt, mask_nxt;
  logic         flip_q, dvd_neg_q, dbz_q;
  logic         load, iter, fix, zero_div;

  assign zero_div = (divisor_i == '0);

  sdiv_ctrl #(.N(N)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_div_i (zero_div),
    .load_o     (load),
    .iter_o     (iter),
    .fix_o      (fix),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  sdiv_step #(.N(N)) i_step (
    .a_i    (a_q),
    .q_i    (q_q),
    .m_i    (m_q),
    .mask_i (mask_q),
    .a_o    (a_nxt),
    .q_o    (q_nxt),
    .mask_o (mask_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q       <= '0;
      q_q       <= '0;
      m_q       <= '0;
      mask_q    <= '0;
      flip_q    <= 1'b0;
      dvd_neg_q <= 1'b0;
      dbz_q     <= 1'b0;
    end else if (load) begin
      a_q       <= {N{dividend_i[N-1]}};
      q_q       <= dividend_i;
      m_q       <= divisor_i;
      mask_q    <= '1;
      flip_q    <= dividend_i[N-1] ^ divisor_i[N-1];
      dvd_neg_q <= dividend_i[N-1];
      dbz_q     <= zero_div;
    end else if (iter) begin
      a_q    <= a_nxt;
      q_q    <= q_nxt;
      mask_q <= mask_nxt;
    end else if (fix && flip_q) begin
      q_q <= '0 - q_q;
    end
  end

  assign quotient_o    = q_q;
  assign remainder_o   = a_q;
  assign div_by_zero_o = dbz_q;

  p_rem_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_by_zero_o) |-> ((remainder_o == '0) || (remainder_o[N-1] == dvd_neg_q)));

  p_dbz_finish_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && div_by_zero_o && !busy_o));

  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(m_q));

  p_no_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && m_q != '0) |-> !div_by_zero_o);
endmodule

// File: tb/test_sdiv_restoring.sv
module test_sdiv_restoring;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dvd = '0, dvs = '0;
  logic         busy, done, dbz;
  logic [N-1:0] quo, rem;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdiv_restoring #(.N(N)) i_sdiv_restoring (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done),
    .quotient_o(quo), .remainder_o(rem), .div_by_zero_o(dbz)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // runs one division; results sampled at the negedge where done is seen
  task automatic run_op(input int x, input int y, output int lat,
                        output logic [N-1:0] q, output logic [N-1:0] r,
                        output logic f, output logic done_next);
    @(negedge clk);
    start = 1'b1; dvd = x[N-1:0]; dvs = y[N-1:0];
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    q = quo; r = rem; f = dbz;
    @(posedge clk); @(negedge clk);
    done_next = done;
  endtask

  task automatic check_div(input string tag, input int x, input int y);
    int lat; logic [N-1:0] q, r; logic f, dn;
    int eq, er;
    run_op(x, y, lat, q, r, f, dn);
    eq = x / y; er = x % y;
    check({tag, " R3"}, $sformatf("quotient %0d/%0d", x, y), int'(q), int'(eq[N-1:0]));
    check({tag, " R4"}, $sformatf("remainder %0d/%0d", x, y), int'(r), int'(er[N-1:0]));
    check("R2", "latency", lat, N + 1);
    check("R2", "done width", int'(dn), 0);
    check("R10", "flag low", int'(f), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat; logic [N-1:0] q, r; logic f, dn;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "dbz", int'(dbz), 0);
    check("R1", "quotient", int'(quo), 0);
    check("R1", "remainder", int'(rem), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 busy rises right after capture
    @(negedge clk);
    start = 1'b1; dvd = 4'd5; dvs = 4'd2;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
    check("R2", "done at busy fall", int'(done), 1);

    // R6 worked examples
    run_op(-7, 2, lat, q, r, f, dn);
    check("R6", "-7/2 quotient", int'(q), 'b1101);
    check("R6", "-7/2 remainder", int'(r), 'b1111);
    run_op(6, -3, lat, q, r, f, dn);
    check("R6", "6/-3 quotient", int'(q), 'b1110);
    check("R6", "6/-3 remainder", int'(r), 0);

    // R5 exact negative divisions
    run_op(-6, 2, lat, q, r, f, dn);
    check("R5", "-6/2 quotient", int'(q), 'b1101);
    check("R5", "-6/2 remainder", int'(r), 0);
    run_op(-4, 2, lat, q, r, f, dn);
    check("R5", "-4/2 quotient", int'(q), 'b1110);
    check("R5", "-4/2 remainder", int'(r), 0);

    // R7 wrap
    run_op(-8, -1, lat, q, r, f, dn);
    check("R7", "-8/-1 quotient", int'(q), 'b1000);
    check("R7", "-8/-1 remainder", int'(r), 0);

    // R8 zero divisor
    run_op(5, 0, lat, q, r, f, dn);
    check("R8", "latency", lat, 0);
    check("R8", "flag", int'(f), 1);
    check("R8", "done width", int'(dn), 0);
    check("R8", "flag held", int'(dbz), 1);
    check("R8", "busy stays low", int'(busy), 0);
    // R10 flag cleared by the next good division
    run_op(7, 3, lat, q, r, f, dn);
    check("R10", "flag cleared", int'(f), 0);
    check("R10", "7/3 quotient", int'(q), 2);

    // R9 start while busy is ignored
    @(negedge clk);
    start = 1'b1; dvd = 4'd5; dvs = 4'd2;
    @(posedge clk); @(negedge clk);
    dvd = 4'd7; dvs = 4'd1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin @(posedge clk); @(negedge clk); lat++; end
    check("R9", "latency", lat, N + 1);
    check("R9", "quotient", int'(quo), 2);
    check("R9", "remainder", int'(rem), 1);

    // R3 R4 exhaustive sweep
    for (int x = -8; x < 8; x++) begin
      for (int y = -8; y < 8; y++) begin
        if (y != 0) check_div("sweep", x, y);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule